// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Capture Controller

This block sequences a multi-channel simultaneous-sampling converter. It pulses the converter's conversion-start line and waits for the falling edge of the busy line, which it passes through a two-flop synchronizer first. It then pulls one result word per channel through a request/valid word port. An external serial engine does the actual shifting. Each word goes out as one beat of a channel-tagged valid/ready sample stream. The block also drives the converter's reset line, its input range select and its three-bit oversampling code.

Conversions are started in one of two ways. A single-shot pulse runs one frame and is guarded by a timeout. A continuous-run level re-launches a conversion as soon as the last sample of the previous frame has been accepted. The converter raises a first-word flag alongside the first channel word. The block checks that flag to confirm the frame is aligned. A missing flag drops the frame, reports an error and runs the converter through a reset and settling sequence.

Range and oversampling settings are taken only while the controller is idle. On the 16-channel variant, a change of the oversampling code forces the same reset and settling sequence.

Back-pressure rule: a presented sample holds its data and tags until `s_ready` is seen high at a clock edge. No further word is requested while a sample is waiting. A low `s_ready` therefore stalls the word port directly.

Top module: `sadc_capture`

## Requirements
- R1: After `rst_n` releases, and after every internal reset, `adc_reset` is high for exactly RESET_CYCLES clocks. A settling window of SETTLE_CYCLES clocks follows, with `adc_convst` low. Only then does `ctl_idle` rise. While `rst_n` is low, `adc_reset` is high and `adc_convst`, `word_req` and `s_valid` are low.
- R2: A `start_single` pulse while idle raises `adc_convst`. After a falling edge of the synchronized busy input, `adc_convst` returns low and CHANNELS words are read, one per `word_req`/`word_valid` handshake, and emitted in channel order 0 to CHANNELS-1.
- R3: Each sample beat carries the word unchanged on `s_data` and its channel index on `s_chan`. `s_sof` is 1 only for channel 0 and `s_eof` is 1 only for channel CHANNELS-1.
- R4: While `s_valid` is high and `s_ready` is low, `s_valid`, `s_data` and `s_chan` stay unchanged. `word_req` is never high while `s_valid` is high.
- R5: With `run_cont` high, `adc_convst` is low throughout the reading of a frame. It rises again right after the last sample is accepted. Once `run_cont` is low at the end of a frame, the controller returns to idle.
- R6: `adc_first` is sampled in the cycle `word_valid` delivers channel 0. If it is low, no sample of that frame is emitted, `err_align` pulses for one cycle and the R1 reset sequence runs.
- R7: A single-shot conversion with no busy falling edge within TIMEOUT_CYCLES clocks ends with a one-cycle `err_timeout` pulse. `adc_convst` is then low and the controller is idle.
- R8: `start_single` is ignored unless the controller is idle. It is also ignored in a cycle where `cfg_load` is high.
- R9: `cfg_load` is accepted only while `ctl_idle` is high. `adc_range` and `adc_os` take the new values one clock later. A load outside idle leaves them unchanged.
- R10: `adc_os` is the log2 of the oversampling ratio. The largest code is 7 when CHANNELS is 16 and 6 otherwise. A larger requested code is saturated to that largest code.
- R11: When CHANNELS is 16, an accepted load that changes the oversampling code starts the R1 reset sequence. A load with the same code does not. Other channel counts never reset on a load.
- R12: `adc_reset` and `adc_convst` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_single | input | 1 | Pulse: start one frame |
| run_cont | input | 1 | Level: run frames back to back |
| cfg_load | input | 1 | Pulse: take cfg_range and cfg_os |
| cfg_range | input | 1 | Requested input range select |
| cfg_os | input | 3 | Requested oversampling code (log2 ratio) |
| adc_convst | output | 1 | Conversion start to converter |
| adc_busy | input | 1 | Converter busy (asynchronous) |
| adc_first | input | 1 | Converter first-word flag |
| adc_reset | output | 1 | Converter reset |
| adc_range | output | 1 | Applied range select |
| adc_os | output | 3 | Applied oversampling code |
| word_req | output | 1 | Request next word from serial engine |
| word_valid | input | 1 | Requested word is present |
| word_data | input | WORD_W | Word from serial engine |
| s_valid | output | 1 | Sample beat present |
| s_ready | input | 1 | Sink accepts beat |
| s_data | output | WORD_W | Sample word |
| s_chan | output | $clog2(CHANNELS) | Channel index of beat |
| s_sof | output | 1 | First beat of frame |
| s_eof | output | 1 | Last beat of frame |
| err_align | output | 1 | Pulse: frame dropped on alignment fault |
| err_timeout | output | 1 | Pulse: single-shot timeout |
| ctl_idle | output | 1 | Controller idle |

## Verification
The bench targets the misaligned frame first. A design that skipped the flag check would stream a shifted frame, and one that forgot the reset would leave the converter misaligned; both show up as unexpected samples or a missing reset pulse of the wrong width. It throttles `s_ready` at random in both single-shot and continuous runs. A design that requested words during a stall, or re-launched a conversion before the last beat was taken, would lose or reorder scoreboard items or show `adc_convst` high during reading. Timeout, start pulses issued mid-frame, configuration loads issued mid-run, and loads with a changed or unchanged oversampling code on the 16- and 4-channel variants each expose a design that reacts when it should not, or the reverse.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [2:0] {
    ST_RST,
    ST_SETTLE,
    ST_IDLE,
    ST_CONV,
    ST_REQ,
    ST_OUT
  } seq_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sadc_busy_sync.sv
module sadc_busy_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_async,
  output logic busy_fall
);
  logic [2:0] stg;

  always_ff @(posedge clk) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[1:0], busy_async};
  end

  assign busy_fall = stg[2] & ~stg[1];
endmodule

// File: rtl/sadc_cfg.sv
module sadc_cfg #(
  parameter int CHANNELS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle,
  input  logic       load,
  input  logic       range_in,
  input  logic [2:0] os_in,
  output logic       range_q,
  output logic [2:0] os_q,
  output logic       os_rst_req
);
  localparam logic [2:0] OS_MAX   = (CHANNELS == 16) ? 3'd7 : 3'd6;
  localparam bit         NEED_RST = (CHANNELS == 16);

  logic [2:0] os_sat;
  assign os_sat = (os_in > OS_MAX) ? OS_MAX : os_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      range_q    <= 1'b0;
      os_q       <= 3'd0;
      os_rst_req <= 1'b0;
    end else begin
      os_rst_req <= 1'b0;
      if (load && idle) begin
        range_q    <= range_in;
        os_q       <= os_sat;
        os_rst_req <= NEED_RST && (os_sat != os_q);
      end
    end
  end
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int CHANNELS       = 8,
  parameter int WORD_W         = 16,
  parameter int RESET_CYCLES   = 5,
  parameter int SETTLE_CYCLES  = 750000,
  parameter int TIMEOUT_CYCLES = 50000000,
  localparam int CH_W  = $clog2(CHANNELS),
  localparam int CNT_W = $clog2(max3(RESET_CYCLES, SETTLE_CYCLES, TIMEOUT_CYCLES) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_single,
  input  logic              run_cont,
  input  logic              cfg_load,
  input  logic              os_rst_req,
  input  logic              busy_fall,
  input  logic              adc_first,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic              s_ready,
  output logic              adc_convst,
  output logic              adc_reset,
  output logic              word_req,
  output logic              s_valid,
  output logic [WORD_W-1:0] s_data,
  output logic [CH_W-1:0]   s_chan,
  output logic              s_sof,
  output logic              s_eof,
  output logic              err_align,
  output logic              err_timeout,
  output logic              idle
);
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RESET_CYCLES - 1);
  localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT_CYCLES - 1);
  localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(CHANNELS - 1);

  seq_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic [CH_W-1:0]  chan;
  logic             cont;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_RST;
      cnt         <= '0;
      chan        <= '0;
      cont        <= 1'b0;
      s_valid     <= 1'b0;
      s_data      <= '0;
      err_align   <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      err_align   <= 1'b0;
      err_timeout <= 1'b0;
      unique case (st)
        ST_RST: begin
          if (cnt == RST_LAST) begin
            cnt <= '0;
            st  <= ST_SETTLE;
          end else cnt <= cnt + 1'b1;
        end
        ST_SETTLE: begin
          if (cnt == SET_LAST) begin
            cnt <= '0;
            st  <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        ST_IDLE: begin
          cnt  <= '0;
          chan <= '0;
          if (os_rst_req) st <= ST_RST;
          else if (!cfg_load) begin
            if (start_single) begin
              cont <= 1'b0;
              st   <= ST_CONV;
            end else if (run_cont) begin
              cont <= 1'b1;
              st   <= ST_CONV;
            end
          end
        end
        ST_CONV: begin
          if (busy_fall) begin
            cnt  <= '0;
            chan <= '0;
            st   <= ST_REQ;
          end else if (!cont && cnt == TMO_LAST) begin
            err_timeout <= 1'b1;
            cnt         <= '0;
            st          <= ST_IDLE;
          end else if (!cont) cnt <= cnt + 1'b1;
        end
        ST_REQ: begin
          if (word_valid) begin
            if (chan == '0 && !adc_first) begin
              err_align <= 1'b1;
              cnt       <= '0;
              st        <= ST_RST;
            end else begin
              s_valid <= 1'b1;
              s_data  <= word_data;
              st      <= ST_OUT;
            end
          end
        end
        ST_OUT: begin
          if (s_ready) begin
            s_valid <= 1'b0;
            if (chan == CH_LAST) begin
              chan <= '0;
              cnt  <= '0;
              st   <= (cont && run_cont) ? ST_CONV : ST_IDLE;
            end else begin
              chan <= chan + 1'b1;
              st   <= ST_REQ;
            end
          end
        end
        default: st <= ST_RST;
      endcase
    end
  end

  assign adc_convst = (st == ST_CONV);
  assign adc_reset  = (st == ST_RST);
  assign word_req   = (st == ST_REQ);
  assign idle       = (st == ST_IDLE);
  assign s_chan     = chan;
  assign s_sof      = (chan == '0);
  assign s_eof      = (chan == CH_LAST);
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
  parameter int CHANNELS       = 8,
  parameter int WORD_W         = 16,
  parameter int RESET_CYCLES   = 5,
  parameter int SETTLE_CYCLES  = 750000,
  parameter int TIMEOUT_CYCLES = 50000000,
  localparam int CH_W = $clog2(CHANNELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_single,
  input  logic              run_cont,
  input  logic              cfg_load,
  input  logic              cfg_range,
  input  logic [2:0]        cfg_os,
  output logic              adc_convst,
  input  logic              adc_busy,
  input  logic              adc_first,
  output logic              adc_reset,
  output logic              adc_range,
  output logic [2:0]        adc_os,
  output logic              word_req,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              s_valid,
  input  logic              s_ready,
  output logic [WORD_W-1:0] s_data,
  output logic [CH_W-1:0]   s_chan,
  output logic              s_sof,
  output logic              s_eof,
  output logic              err_align,
  output logic              err_timeout,
  output logic              ctl_idle
);
  logic busy_fall;
  logic os_rst_req;

  sadc_busy_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_async (adc_busy),
    .busy_fall  (busy_fall)
  );

  sadc_cfg #(.CHANNELS(CHANNELS)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle       (ctl_idle),
    .load       (cfg_load),
    .range_in   (cfg_range),
    .os_in      (cfg_os),
    .range_q    (adc_range),
    .os_q       (adc_os),
    .os_rst_req (os_rst_req)
  );

  sadc_seq #(
    .CHANNELS       (CHANNELS),
    .WORD_W         (WORD_W),
    .RESET_CYCLES   (RESET_CYCLES),
    .SETTLE_CYCLES  (SETTLE_CYCLES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_single (start_single),
    .run_cont     (run_cont),
    .cfg_load     (cfg_load),
    .os_rst_req   (os_rst_req),
    .busy_fall    (busy_fall),
    .adc_first    (adc_first),
    .word_valid   (word_valid),
    .word_data    (word_data),
    .s_ready      (s_ready),
    .adc_convst   (adc_convst),
    .adc_reset    (adc_reset),
    .word_req     (word_req),
    .s_valid      (s_valid),
    .s_data       (s_data),
    .s_chan       (s_chan),
    .s_sof        (s_sof),
    .s_eof        (s_eof),
    .err_align    (err_align),
    .err_timeout  (err_timeout),
    .idle         (ctl_idle)
  );
endmodule

// File: rtl/sadc_capture_chk.sv
module sadc_capture_chk #(
  parameter int CHANNELS = 8,
  parameter int WORD_W   = 16,
  localparam int CH_W = $clog2(CHANNELS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adc_convst,
  input logic              adc_reset,
  input logic              adc_range,
  input logic [2:0]        adc_os,
  input logic              word_req,
  input logic              s_valid,
  input logic              s_ready,
  input logic [WORD_W-1:0] s_data,
  input logic [CH_W-1:0]   s_chan,
  input logic              err_align,
  input logic              err_timeout,
  input logic              ctl_idle
);
  localparam logic [2:0] OS_TOP = (CHANNELS == 16) ? 3'd7 : 3'd6;

  // R4
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && !s_ready |=> s_valid && $stable(s_data) && $stable(s_chan));

  // R4
  one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_req && s_valid));

  // R12
  rst_conv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(adc_reset && adc_convst));

  // R6
  align_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_align |-> adc_reset && !s_valid);

  // R7
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> ctl_idle && !adc_convst);

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_idle |=> $stable(adc_os) && $stable(adc_range));

  // R10
  os_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_os <= OS_TOP);
endmodule

bind sadc_capture sadc_capture_chk #(.CHANNELS(CHANNELS), .WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .adc_convst  (adc_convst),
  .adc_reset   (adc_reset),
  .adc_range   (adc_range),
  .adc_os      (adc_os),
  .word_req    (word_req),
  .s_valid     (s_valid),
  .s_ready     (s_ready),
  .s_data      (s_data),
  .s_chan      (s_chan),
  .err_align   (err_align),
  .err_timeout (err_timeout),
  .ctl_idle    (ctl_idle)
);

// File: tb/sadc_capture_test.sv
`timescale 1ns/1ps
module sadc_capture_test;
  localparam int NCH = 16;
  localparam int WW  = 16;
  localparam int RC  = 4;
  localparam int SC  = 25;
  localparam int TC  = 300;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic start_single = 0, run_cont = 0, cfg_load = 0, cfg_range = 0;
  logic [2:0] cfg_os = 0;
  logic adc_convst, adc_reset, adc_range, word_req, s_valid, s_sof, s_eof;
  logic err_align, err_timeout, ctl_idle;
  logic [2:0] adc_os;
  logic adc_busy = 0, adc_first = 0, word_valid = 0, s_ready = 1;
  logic [WW-1:0] word_data = 0, s_data;
  logic [3:0] s_chan;

  sadc_capture #(.CHANNELS(NCH), .WORD_W(WW), .RESET_CYCLES(RC),
                 .SETTLE_CYCLES(SC), .TIMEOUT_CYCLES(TC)) uut (
    .clk(clk), .rst_n(rst_n), .start_single(start_single), .run_cont(run_cont),
    .cfg_load(cfg_load), .cfg_range(cfg_range), .cfg_os(cfg_os),
    .adc_convst(adc_convst), .adc_busy(adc_busy), .adc_first(adc_first),
    .adc_reset(adc_reset), .adc_range(adc_range), .adc_os(adc_os),
    .word_req(word_req), .word_valid(word_valid), .word_data(word_data),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_chan(s_chan),
    .s_sof(s_sof), .s_eof(s_eof), .err_align(err_align),
    .err_timeout(err_timeout), .ctl_idle(ctl_idle));

  // 4-channel instance, configuration checks only
  logic cv4, rs4, rg4, wr4, sv4, sf4, ef4, ea4, et4, id4;
  logic [2:0] os4;
  logic [WW-1:0] sd4;
  logic [1:0] sc4;
  sadc_capture #(.CHANNELS(4), .WORD_W(WW), .RESET_CYCLES(RC),
                 .SETTLE_CYCLES(SC), .TIMEOUT_CYCLES(TC)) uut4 (
    .clk(clk), .rst_n(rst_n), .start_single(1'b0), .run_cont(1'b0),
    .cfg_load(cfg_load), .cfg_range(cfg_range), .cfg_os(cfg_os),
    .adc_convst(cv4), .adc_busy(1'b0), .adc_first(1'b0),
    .adc_reset(rs4), .adc_range(rg4), .adc_os(os4),
    .word_req(wr4), .word_valid(1'b0), .word_data('0),
    .s_valid(sv4), .s_ready(1'b1), .s_data(sd4), .s_chan(sc4),
    .s_sof(sf4), .s_eof(ef4), .err_align(ea4),
    .err_timeout(et4), .ctl_idle(id4));

  // converter and serial-engine model
  bit busy_en = 1, skew = 0;
  logic conv_d = 0;
  int bcnt = 0, widx = 0, fr = 0;
  always @(posedge clk) begin
    conv_d <= adc_convst;
    if (adc_reset) begin
      bcnt <= 0; widx <= 0; adc_busy <= 0;
    end else begin
      if (adc_convst && !conv_d) begin
        fr <= fr + 1; widx <= 0;
        if (busy_en) bcnt <= 1;
      end else if (bcnt != 0) bcnt <= (bcnt == 14) ? 0 : bcnt + 1;
      adc_busy <= (bcnt >= 3 && bcnt < 13);
    end
    if (word_req && !word_valid) begin
      word_valid <= 1;
      word_data  <= {fr[7:0], widx[7:0]};
      adc_first  <= (widx == 0) && !skew;
      widx       <= widx + 1;
    end else begin
      word_valid <= 0;
      adc_first  <= 0;
    end
  end

  int total = 0, bad = 0;
  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard
  int exp_q[$];
  task automatic exp_frame(input int f);
    for (int c = 0; c < NCH; c++) exp_q.push_back({f[7:0], c[7:0]});
  endtask

  bit stall = 0;
  logic [15:0] lfsr = 16'hACE1;
  int conv_bad = 0, excl_bad = 0, n_align = 0, n_tmo = 0, n_rise = 0, n_rst = 0;
  int n_rst4 = 0, rlen = 0, slen = 0, last_rlen = 0, last_slen = 0;
  bit settling = 0, conv_p = 0, rst_p = 0, rst4_p = 0;

  initial forever begin
    @(negedge clk);
    if (stall) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s_ready = lfsr[0] | lfsr[3];
    end else s_ready = 1;
    if (rst_n) begin
      if (s_valid && s_ready) begin
        if (exp_q.size() == 0) chk("R6 unexpected sample", int'(s_data), -1);
        else begin
          int w;
          w = exp_q.pop_front();
          chk("R2 sample word", int'(s_data), w);
          chk("R3 channel tag", int'(s_chan), w & 8'hFF);
          chk("R3 first tag", int'(s_sof), int'((w & 8'hFF) == 0));
          chk("R3 last tag", int'(s_eof), int'((w & 8'hFF) == NCH - 1));
        end
      end
      if (s_valid && adc_convst) conv_bad++;
      if (adc_reset && adc_convst) excl_bad++;
      if (err_align) n_align++;
      if (err_timeout) n_tmo++;
      if (adc_convst && !conv_p) n_rise++;
      conv_p = adc_convst;
      if (rs4 && !rst4_p) n_rst4++;
      rst4_p = rs4;
      if (adc_reset && !rst_p) begin n_rst++; rlen = 0; end
      if (adc_reset) begin rlen++; slen = 0; settling = 1; last_rlen = rlen; end
      else if (settling) begin
        if (ctl_idle) begin settling = 0; last_slen = slen; end
        else slen++;
      end
      rst_p = adc_reset;
    end
  end

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2000 && !ctl_idle; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_single = 1;
    @(negedge clk); start_single = 0;
  endtask

  task automatic pulse_load(input logic [2:0] os, input logic rng);
    @(negedge clk); cfg_os = os; cfg_range = rng; cfg_load = 1;
    @(negedge clk); cfg_load = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int nf = 0, b_rise, b_rst, b_al, b_tmo, t0;
  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset drives adc_reset", int'(adc_reset), 1);
    chk("R1 reset convst low", int'(adc_convst), 0);
    chk("R1 reset s_valid low", int'(s_valid), 0);
    chk("R1 reset word_req low", int'(word_req), 0);
    #1 rst_n = 1;
    wait_idle();
    chk("R1 settle length", last_slen, SC);

    // R2 R3 single frame
    b_rise = n_rise; nf++; exp_frame(nf);
    pulse_start(); wait_idle();
    chk("R2 frame drained", exp_q.size(), 0);
    chk("R2 one conversion", n_rise - b_rise, 1);

    // R4 stalled sink
    stall = 1; nf++; exp_frame(nf);
    pulse_start(); wait_idle();
    chk("R4 stalled frame drained", exp_q.size(), 0);
    stall = 0;

    // R8 start mid-frame ignored
    b_rise = n_rise; nf++; exp_frame(nf);
    pulse_start();
    for (int i = 0; i < 500 && !s_valid; i++) @(negedge clk);
    pulse_start(); wait_idle();
    chk("R8 mid-frame start ignored", n_rise - b_rise, 1);
    chk("R8 frame drained", exp_q.size(), 0);

    // R5 continuous with stalls, R9 load refused while running
    stall = 1; b_rise = n_rise;
    exp_frame(nf + 1); exp_frame(nf + 2); exp_frame(nf + 3); nf += 3;
    @(negedge clk); run_cont = 1;
    for (int i = 0; i < 5000 && n_rise < b_rise + 1; i++) @(negedge clk);
    pulse_load(3'd5, 1'b1);
    chk("R9 os unchanged mid-run", int'(adc_os), 0);
    chk("R9 range unchanged mid-run", int'(adc_range), 0);
    for (int i = 0; i < 5000 && n_rise < b_rise + 3; i++) @(negedge clk);
    run_cont = 0;
    wait_idle();
    stall = 0;
    chk("R5 three frames", n_rise - b_rise, 3);
    chk("R5 continuous drained", exp_q.size(), 0);
    chk("R5 convst low while reading", conv_bad, 0);

    // R6 misaligned frame
    b_al = n_align; b_rst = n_rst;
    skew = 1; nf++;
    pulse_start(); wait_idle();
    skew = 0;
    chk("R6 align error pulse", n_align - b_al, 1);
    chk("R6 reset issued", n_rst - b_rst, 1);
    chk("R1 reset pulse width", last_rlen, RC);
    chk("R1 settle after fault", last_slen, SC);
    nf++; exp_frame(nf);
    pulse_start(); wait_idle();
    chk("R6 recovery frame", exp_q.size(), 0);

    // R7 timeout
    busy_en = 0; b_tmo = n_tmo; nf++;
    pulse_start(); t0 = 0;
    for (int i = 0; i < 2000 && !ctl_idle; i++) begin @(negedge clk); t0++; end
    chk("R7 timeout pulse", n_tmo - b_tmo, 1);
    chk("R7 convst low", int'(adc_convst), 0);
    chk("R7 waited full window", int'(t0 >= TC - 2), 1);
    busy_en = 1;
    wait_idle();

    // R9 R11 configuration
    b_rst = n_rst;
    pulse_load(3'd3, 1'b1);
    chk("R9 os applied", int'(adc_os), 3);
    chk("R9 range applied", int'(adc_range), 1);
    wait_idle();
    chk("R11 os change resets", n_rst - b_rst, 1);
    b_rst = n_rst;
    pulse_load(3'd3, 1'b0);
    chk("R9 range cleared", int'(adc_range), 0);
    repeat (10) @(negedge clk);
    chk("R11 same os no reset", n_rst - b_rst, 0);
    chk("R11 still idle", int'(ctl_idle), 1);

    // R10 ceilings
    pulse_load(3'd7, 1'b0);
    chk("R10 16-ch code 7", int'(adc_os), 7);
    chk("R10 4-ch saturates", int'(os4), 6);
    wait_idle();
    chk("R11 4-ch never resets", n_rst4, 1);

    // R8 start with load same cycle
    b_rise = n_rise;
    @(negedge clk); start_single = 1; cfg_load = 1;
    @(negedge clk); start_single = 0; cfg_load = 0;
    repeat (10) @(negedge clk);
    chk("R8 start with load ignored", n_rise - b_rise, 0);

    chk("R12 reset and convst exclusive", excl_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule